// File: doc/BRIEF.md
# Multi-Pass Interleaved Capture Sequencer

This block rebuilds a 104-bit bus snapshot, one word for every tick of the capture clock, from a capture path that is only one byte wide and takes a byte on every third tick. The target system is made to repeat the same run 48 times. For each run the block sets an external 3-bit multiplexer select, a port select and a sub-sample phase offset, and then waits for a synchronisation pulse from outside. After the pulse it stores one slice on every third clock, at the tick chosen by the phase. The runs go through every combination: 3 phases for each port, 2 ports for each multiplexer setting, 8 multiplexer settings.

Each multiplexer setting exposes 13 bus bits. Port 0 carries 8 of them and port 1 carries 5. After the last run the block raises a done flag. A read port then accepts a tick index and returns the reassembled 104-bit word for that tick. To build the word it fetches the 16 slices stored for that tick (one for each multiplexer setting and port) in parallel. A sync pulse that arrives during an active run does not change the run and sets a sticky error flag.

Top module: `mpcap_sequencer`

## Requirements
- R1: After a synchronous active-low reset, mux_sel_o = 0, port_sel_o = 0, phase_o = 0, busy_o = 0, done_o = 0, sync_err_o = 0 and rd_word_o = 0.
- R2: A sync_i high at a clock edge while busy_o is low and done_o is low starts a run, and busy_o is high from that edge on. The first busy cycle is tick 0.
- R3: During a run, the slice on slice_i is stored at the edge that ends tick t exactly when t mod 3 equals phase_o. busy_o falls at the edge that ends tick 3*(SAMPLES_PER_PASS-1)+phase_o.
- R4: Run order: phase_o steps 0,1,2 innermost, then port_sel_o 0,1, then mux_sel_o 0..7. The selects change only at the edge where busy_o falls and hold steady while busy_o is high.
- R5: At the end of the run with mux 7, port 1 and phase 2, done_o goes high. The selects then hold those values, and further sync pulses start nothing.
- R6: A sync_i high while busy_o is high does not change the run timing or the selects. It sets sync_err_o, which stays high until reset.
- R7: rd_word_o is registered and, one clock after rd_tick_i = t (t < 3*SAMPLES_PER_PASS), equals the bus word at tick t. Bits [13m+7:13m] come from the port 0 slice at mux setting m, and bits [13m+12:13m+8] come from bits 4:0 of the port 1 slice at mux setting m.
- R8: Bits 7:5 of slice_i are discarded during port 1 runs and have no effect on any bit of rd_word_o.
- R9: A sync_i high at the first edge after busy_o falls is accepted and starts the next run with no idle gap.
- R10: A read index rd_tick_i of 3*SAMPLES_PER_PASS or more returns an all-zero rd_word_o one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, three times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Per-run synchronisation pulse from the target |
| slice_i | input | 8 | Narrow capture path, the byte from the selected port |
| rd_tick_i | input | TICK_W | Tick index to reassemble |
| mux_sel_o | output | 3 | External bus multiplexer select |
| port_sel_o | output | 1 | Selects the 8-bit port (0) or the 5-bit port (1) |
| phase_o | output | 2 | Sub-sample phase offset of the current run (0..2) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | All 48 runs are complete |
| sync_err_o | output | 1 | Sticky: a sync arrived during a run |
| rd_word_o | output | 104 | Reassembled bus word for the requested tick |

## Verification
The bench gives each tick a different 104-bit word and acts as the external multiplexer, driving from the current selects. Any slip in the run order, phase or sample position therefore shows up as a wrong word on readback. Bits 7:5 of slice_i are held at ones during port 1 runs, which shows whether those bits leak into the neighbouring lane. Two capture rounds use different data patterns. The first derives every byte from an arithmetic mix of the tick and the lane. The second puts the tick in the high bits, which separates the phase slots from one another. Gaps of zero, one and two cycles between runs, a sync injected in the middle of a run, and syncs after completion test the sequencing against a reference model that is compared on every clock.

// File: rtl/mpcap_pkg.sv
// Shared constants and types for the multi-pass capture sequencer.
// Assumes a fixed capture structure: 8 mux settings, 2 ports, 3 phases.
package mpcap_pkg;
    localparam int MUX_N      = 8;
    localparam int SEL_W      = 3;
    localparam int PORT_N     = 2;
    localparam int PHASE_N    = 3;
    localparam int PASS_N     = MUX_N * PORT_N * PHASE_N;
    localparam int PASS_W     = $clog2(PASS_N);
    localparam int SLICE_W    = 8;
    localparam int NARROW_W   = 5;
    localparam int LANE_W     = SLICE_W + NARROW_W;
    localparam int WORD_W     = MUX_N * LANE_W;
    localparam int READ_LANES = MUX_N * PORT_N;

    typedef logic [SLICE_W-1:0] slice_t;
endpackage

// File: rtl/mpcap_ctrl.sv
// Run sequencer: steps phase, port and mux select in that nesting order,
// starts a run on sync, then issues a store every third tick at the
// tick chosen by the phase. Assumes SAMPLES >= 2.
module mpcap_ctrl
    import mpcap_pkg::*;
#(
    parameter int SAMPLES = 8,
    localparam int SAMP_W = $clog2(SAMPLES),
    localparam int ADDR_W = $clog2(PASS_N * SAMPLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    output logic [SEL_W-1:0]  mux_sel_o,
    output logic              port_sel_o,
    output logic [1:0]        phase_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              sync_err_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o
);
    logic [1:0]        sub_q;
    logic [SAMP_W-1:0] samp_q;
    logic [PASS_W-1:0] pass_idx;
    logic              last_store;
    logic              final_pass;

    // Linear run number from the three select counters.
    assign pass_idx   = PASS_W'((int'(mux_sel_o) * PORT_N + int'(port_sel_o)) * PHASE_N
                                + int'(phase_o));
    // Store strobe: busy and at the sub-tick that matches the phase.
    assign wr_en_o    = busy_o && (sub_q == phase_o);
    assign last_store = wr_en_o && (samp_q == SAMP_W'(SAMPLES - 1));
    assign final_pass = (mux_sel_o == SEL_W'(MUX_N - 1)) && port_sel_o
                        && (phase_o == 2'(PHASE_N - 1));
    assign wr_addr_o  = ADDR_W'(int'(pass_idx) * SAMPLES + int'(samp_q));

    // Run state, tick counters, run order and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_sel_o  <= '0;
            port_sel_o <= 1'b0;
            phase_o    <= '0;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
            sync_err_o <= 1'b0;
            sub_q      <= '0;
            samp_q     <= '0;
        end else begin
            if (sync_i && busy_o) begin
                sync_err_o <= 1'b1;
            end
            if (!busy_o) begin
                if (sync_i && !done_o) begin
                    busy_o <= 1'b1;
                    sub_q  <= '0;
                    samp_q <= '0;
                end
            end else begin
                sub_q <= (sub_q == 2'(PHASE_N - 1)) ? 2'd0 : sub_q + 2'd1;
                if (sub_q == 2'(PHASE_N - 1)) begin
                    samp_q <= samp_q + SAMP_W'(1);
                end
                if (last_store) begin
                    busy_o <= 1'b0;
                    if (final_pass) begin
                        done_o <= 1'b1;
                    end else if (phase_o != 2'(PHASE_N - 1)) begin
                        phase_o <= phase_o + 2'd1;
                    end else begin
                        phase_o <= '0;
                        if (!port_sel_o) begin
                            port_sel_o <= 1'b1;
                        end else begin
                            port_sel_o <= 1'b0;
                            mux_sel_o  <= mux_sel_o + SEL_W'(1);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mpcap_store.sv
// Slice buffer: one write port and READ_LANES parallel combinational
// read lanes. Narrow-port slices are stored with their unused bits zero.
// Assumes addresses in range on writes.
module mpcap_store
    import mpcap_pkg::*;
#(
    parameter int DEPTH  = 384,
    parameter int ADDR_W = 9
) (
    input  logic                                   clk,
    input  logic                                   wr_en_i,
    input  logic                                   wr_narrow_i,
    input  logic [ADDR_W-1:0]                      wr_addr_i,
    input  slice_t                                 wr_data_i,
    input  logic [READ_LANES-1:0][ADDR_W-1:0]      rd_addr_i,
    output logic [READ_LANES-1:0][SLICE_W-1:0]     rd_data_o
);
    localparam slice_t NARROW_MASK = slice_t'((1 << NARROW_W) - 1);

    slice_t mem [DEPTH];

    // Write one slice, clearing the bits the narrow port does not carry.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_addr_i] <= wr_narrow_i ? (wr_data_i & NARROW_MASK) : wr_data_i;
        end
    end

    for (genvar g = 0; g < READ_LANES; g++) begin : g_rd
        assign rd_data_o[g] = mem[rd_addr_i[g]];
    end
endmodule

// File: rtl/mpcap_reasm.sv
// Reassembly read path: splits a tick index into phase and sample,
// addresses all 16 slices of that tick, packs them into the wide word
// and registers it. Out-of-range indices give zero.
module mpcap_reasm
    import mpcap_pkg::*;
#(
    parameter int SAMPLES = 8,
    parameter int TICK_W  = 5,
    parameter int ADDR_W  = 9
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [TICK_W-1:0]                   rd_tick_i,
    output logic [READ_LANES-1:0][ADDR_W-1:0]   rd_addr_o,
    input  logic [READ_LANES-1:0][SLICE_W-1:0]  rd_data_i,
    output logic [WORD_W-1:0]                   rd_word_o
);
    logic [1:0]        tick_phase;
    logic [TICK_W-1:0] tick_samp;
    logic              in_range;
    logic [WORD_W-1:0] word;
    logic [MUX_N*(SLICE_W-NARROW_W)-1:0] unused_hi;

    // Tick index to (phase, sample) decomposition.
    assign tick_phase = 2'(rd_tick_i % TICK_W'(PHASE_N));
    assign tick_samp  = rd_tick_i / TICK_W'(PHASE_N);
    assign in_range   = int'(rd_tick_i) < PHASE_N * SAMPLES;

    // Lane g is run group g = mux*2 + port; its run is g*3 + phase.
    for (genvar g = 0; g < READ_LANES; g++) begin : g_addr
        assign rd_addr_o[g] = ADDR_W'((g * PHASE_N + int'(tick_phase)) * SAMPLES
                                      + int'(tick_samp));
    end

    for (genvar m = 0; m < MUX_N; m++) begin : g_pack
        assign word[m*LANE_W +: SLICE_W]            = rd_data_i[2*m];
        assign word[m*LANE_W+SLICE_W +: NARROW_W]   = rd_data_i[2*m+1][NARROW_W-1:0];
        assign unused_hi[m*(SLICE_W-NARROW_W) +: (SLICE_W-NARROW_W)] =
            rd_data_i[2*m+1][SLICE_W-1:NARROW_W];
    end

    // Output register for the reassembled word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word_o <= '0;
        end else begin
            rd_word_o <= in_range ? word : '0;
        end
    end
endmodule

// File: rtl/mpcap_sequencer.sv
// Top level: multi-pass interleaved capture sequencer. Drives the
// external select lines, captures slices over 48 repeated runs and
// reassembles full-width words on read. Assumes the target repeats
// the same behaviour after every sync pulse.
module mpcap_sequencer
    import mpcap_pkg::*;
#(
    parameter int SAMPLES_PER_PASS = 8,
    localparam int TICK_W = $clog2(PHASE_N * SAMPLES_PER_PASS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [7:0]        slice_i,
    input  logic [TICK_W-1:0] rd_tick_i,
    output logic [2:0]        mux_sel_o,
    output logic              port_sel_o,
    output logic [1:0]        phase_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              sync_err_o,
    output logic [103:0]      rd_word_o
);
    localparam int DEPTH  = PASS_N * SAMPLES_PER_PASS;
    localparam int ADDR_W = $clog2(DEPTH);

    logic                                  wr_en;
    logic [ADDR_W-1:0]                     wr_addr;
    logic [READ_LANES-1:0][ADDR_W-1:0]     rd_addr;
    logic [READ_LANES-1:0][SLICE_W-1:0]    rd_data;

    mpcap_ctrl #(.SAMPLES(SAMPLES_PER_PASS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .mux_sel_o  (mux_sel_o),
        .port_sel_o (port_sel_o),
        .phase_o    (phase_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .sync_err_o (sync_err_o),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr)
    );

    mpcap_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk         (clk),
        .wr_en_i     (wr_en),
        .wr_narrow_i (port_sel_o),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (slice_i),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data)
    );

    mpcap_reasm #(.SAMPLES(SAMPLES_PER_PASS), .TICK_W(TICK_W), .ADDR_W(ADDR_W)) u_reasm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_tick_i (rd_tick_i),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .rd_word_o (rd_word_o)
    );
endmodule

// File: rtl/mpcap_checker.sv
// Protocol checker for the capture sequencer, attached with bind.
// Watches only the top-level ports.
module mpcap_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_i,
    input logic [2:0] mux_sel_o,
    input logic       port_sel_o,
    input logic [1:0] phase_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       sync_err_o
);
    // R2: an idle, unfinished sequencer starts a run on sync.
    assert_sync_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !busy_o && !done_o) |=> busy_o);

    // R2: a run only begins after a sync.
    assert_start_needs_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(sync_i));

    // R4: selects hold while a run is active.
    assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(mux_sel_o) && $stable(port_sel_o)
                                        && $stable(phase_o)));

    // R4: phase steps by one inside a port/mux group.
    assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !done_o && ($past(phase_o) != 2'd2)) |->
        ((phase_o == $past(phase_o) + 2'd1) && (port_sel_o == $past(port_sel_o))
         && (mux_sel_o == $past(mux_sel_o))));

    // R4: phase offset never leaves 0..2.
    assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o != 2'd3);

    // R5: completion is terminal until reset.
    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && !busy_o && $stable(mux_sel_o) && $stable(phase_o)));

    // R6: sync during a run flags an error.
    assert_sync_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && busy_o) |=> sync_err_o);

    // R6: the error flag is sticky.
    assert_sync_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |=> sync_err_o);
endmodule

bind mpcap_sequencer mpcap_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_i),
    .mux_sel_o  (mux_sel_o),
    .port_sel_o (port_sel_o),
    .phase_o    (phase_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sync_err_o (sync_err_o)
);

// File: tb/sim_mpcap_sequencer.sv
// Bench: behavioural reference model compared on every clock, plus a
// full readback of the reassembled words after each capture round.
module sim_mpcap_sequencer;
    localparam int S          = 8;
    localparam int TICK_W     = $clog2(3 * S);
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_i = 1'b0;
    logic [7:0]        slice_i = 8'h00;
    logic [TICK_W-1:0] rd_tick_i = '0;
    logic [2:0]        mux_sel_o;
    logic              port_sel_o;
    logic [1:0]        phase_o;
    logic              busy_o;
    logic              done_o;
    logic              sync_err_o;
    logic [103:0]      rd_word_o;

    int n_chk  = 0;
    int n_fail = 0;
    int pat_r  = 0;
    bit finished = 1'b0;

    // Reference model state.
    int m_mux = 0, m_port = 0, m_phase = 0, m_tick = 0;
    bit m_busy = 1'b0, m_done = 1'b0, m_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpcap_sequencer #(.SAMPLES_PER_PASS(S)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .slice_i(slice_i),
        .rd_tick_i(rd_tick_i), .mux_sel_o(mux_sel_o), .port_sel_o(port_sel_o),
        .phase_o(phase_o), .busy_o(busy_o), .done_o(done_o),
        .sync_err_o(sync_err_o), .rd_word_o(rd_word_o)
    );

    // Bus contents seen by the target at each tick, per pattern.
    function automatic logic [103:0] bus_val(int pat, int t);
        logic [103:0] w;
        for (int i = 0; i < 13; i++) begin
            if (pat == 0) w[8*i +: 8] = 8'(t * 29 + i * 53 + 7);
            else          w[8*i +: 8] = 8'((t << 3) ^ (i * 17) ^ 8'hC3);
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [103:0] act, input logic [103:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model, advanced on each rising edge from the bench inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mux = 0; m_port = 0; m_phase = 0; m_tick = 0;
            m_busy = 0; m_done = 0; m_err = 0;
        end else begin
            if (sync_i && m_busy) m_err = 1;
            if (!m_busy) begin
                if (sync_i && !m_done) begin
                    m_busy = 1;
                    m_tick = 0;
                end
            end else begin
                if (m_tick == 3 * (S - 1) + m_phase) begin
                    m_busy = 0;
                    if (m_mux == 7 && m_port == 1 && m_phase == 2) m_done = 1;
                    else if (m_phase != 2) m_phase++;
                    else begin
                        m_phase = 0;
                        if (m_port == 0) m_port = 1;
                        else begin m_port = 0; m_mux++; end
                    end
                end
                m_tick++;
            end
        end
    end

    // External mux emulation: present the selected slice for the current tick.
    // Port 1 upper bits are driven high so any leak is visible (R8).
    always @(negedge clk) begin
        logic [103:0] w;
        int m;
        if (m_busy) begin
            w = bus_val(pat_r, m_tick);
            m = int'(mux_sel_o);
            slice_i = port_sel_o ? {3'b111, w[13*m+8 +: 5]} : w[13*m +: 8];
        end else begin
            slice_i = 8'h5A;
        end
    end

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                chk(mux_sel_o == 3'(m_mux) && port_sel_o == m_port[0] && phase_o == 2'(m_phase),
                    "R1 selects", {mux_sel_o, port_sel_o, phase_o}, {3'(m_mux), m_port[0], 2'(m_phase)});
            end else begin
                chk(mux_sel_o == 3'(m_mux) && port_sel_o == m_port[0] && phase_o == 2'(m_phase),
                    "R4 run order", {mux_sel_o, port_sel_o, phase_o}, {3'(m_mux), m_port[0], 2'(m_phase)});
            end
            chk(busy_o == m_busy, "R2 R3 busy", busy_o, m_busy);
            chk(done_o == m_done, "R5 done", done_o, m_done);
            chk(sync_err_o == m_err, "R6 sync error", sync_err_o, m_err);
        end
    end

    task automatic run_capture(input int pat, input bit inject);
        pat_r = pat;
        for (int p = 0; p < 48; p++) begin
            while (m_busy) @(negedge clk);
            repeat (p % 3) @(negedge clk);   // gap 0 exercises R9
            sync_i = 1'b1;
            @(negedge clk);
            sync_i = 1'b0;
            if (inject && p == 5) begin      // R6: sync in mid-run
                repeat (4) @(negedge clk);
                sync_i = 1'b1;
                @(negedge clk);
                sync_i = 1'b0;
            end
        end
        while (m_busy) @(negedge clk);
        // R5: syncs after completion start nothing
        repeat (2) begin
            @(negedge clk); sync_i = 1'b1;
            @(negedge clk); sync_i = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(done_o == 1'b1 && busy_o == 1'b0, "R5 terminal", {done_o, busy_o}, 2'b10);
    endtask

    task automatic readback(input int pat);
        for (int t = 0; t < (1 << TICK_W); t++) begin
            logic [103:0] exp;
            rd_tick_i = TICK_W'(t);
            @(negedge clk);
            exp = (t < 3 * S) ? bus_val(pat, t) : '0;
            chk(rd_word_o === exp, (t < 3 * S) ? "R7 R8 word" : "R10 out of range",
                rd_word_o, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_word_o == '0 && !busy_o && !done_o && !sync_err_o, "R1 reset",
            {rd_word_o, busy_o, done_o, sync_err_o}, '0);
        rst_n = 1'b1;
        run_capture(0, 1'b1);
        readback(0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sync_err_o == 1'b0 && rd_word_o == '0, "R1 R6 cleared by reset",
            {sync_err_o, rd_word_o}, '0);
        rst_n = 1'b1;
        run_capture(1, 1'b0);
        readback(1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule